// File: doc/BRIEF.md
# Saturating Unsigned Narrowing Shift Unit

This block narrows a packed vector of signed wide elements into unsigned half-width values. Each element is shifted right arithmetically by an immediate amount, optionally rounded, and clamped to the unsigned range of the half width. The narrowed value then lands in the low half of its container, with the high half cleared, or in the high half, with the low half copied from the old destination vector. An execution pipeline presents the source vector, the old destination vector, an element-size code, the shift amount and a 4-bit operation code together with a valid strobe. The new destination vector comes back one clock later with its own strobe.

Control is a two-state machine. `ST_IDLE` waits for a legal request. The transition `accept` (valid strobe high with a legal size and opcode) loads the output register and enters `ST_EMIT`. `ST_EMIT` drives the output strobe for exactly one cycle. From there it takes `accept` again on a back-to-back legal request, or `drain` back to `ST_IDLE` otherwise. In `ST_IDLE`, the transition `hold` (no legal request) keeps the state and the output register unchanged.

Top module: `snsu_top`

## Requirements
- R1: `elem_size` selects the container width: 1 means 16-bit sources and 8-bit results, 2 means 32-bit sources and 16-bit results, 3 means 64-bit sources and 32-bit results. Container c occupies bits [c*W +: W] of each vector.
- R2: Without rounding, each source is shifted right arithmetically (sign-filling) by `shift_amt`. A shift amount of W or more acts as a shift of W-1.
- R3: The shifted value is clamped. A negative value becomes 0, and a value above 2^(W/2)-1 becomes all ones in the half-width field.
- R4: With rounding, bit (`shift_amt`-1) of the original source is added to the shifted value before clamping. Headroom is kept, so the largest positive source cannot wrap. A shift of 0 adds nothing. A shift of W or more gives 0.
- R5: Bottom placement writes the narrowed value to the low half of each container and zero to the high half.
- R6: Top placement writes the narrowed value to the high half of each container and keeps the low half from `dst_vec`.
- R7: `op_code` 4'b0000 selects plain bottom, 4'b0001 plain top, 4'b0010 rounding bottom and 4'b0011 rounding top. Bit 0 picks top placement and bit 1 picks rounding.
- R8: An accepted request raises `out_valid` for exactly one cycle on the next clock, with `out_vec` updated on that same edge.
- R9: A request with `elem_size` 0 or with `op_code` above 4'b0011 is dropped. `out_valid` stays low and `out_vec` keeps its value.
- R10: While `rst_n` is low, `out_valid` and `out_vec` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| src_vec | input | VEC_W | Packed signed wide source elements |
| dst_vec | input | VEC_W | Old destination vector (low halves kept in top mode) |
| elem_size | input | 2 | Container size code (1, 2, 3) |
| shift_amt | input | 7 | Right shift amount, 0 to 127 |
| op_code | input | 4 | Operation select |
| out_valid | output | 1 | Result strobe |
| out_vec | output | VEC_W | New destination vector |

## Verification
Every result is due exactly one clock after the edge that accepts its request. The bench drives a request on a falling edge and removes it on the next falling edge. It samples `out_valid` and `out_vec` at that second falling edge, after the one rising edge that registers them. One falling edge later it confirms that the strobe has dropped and the vector is held. Dropped requests are checked at the same sampling point: the strobe must be low and the vector must be unchanged.

// File: rtl/snsu_pkg.sv
package snsu_pkg;

    typedef enum logic [3:0] {
        OP_PLAIN_LO = 4'b0000,
        OP_PLAIN_HI = 4'b0001,
        OP_ROUND_LO = 4'b0010,
        OP_ROUND_HI = 4'b0011
    } snsu_op_e;

    typedef enum logic [1:0] {
        SZ_NONE = 2'd0,
        SZ_16   = 2'd1,
        SZ_32   = 2'd2,
        SZ_64   = 2'd3
    } snsu_size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } snsu_state_e;

    typedef struct packed {
        logic legal;
        logic rnd;
        logic top;
    } snsu_ctl_t;

    localparam int SHIFT_W = 7;

    function automatic snsu_ctl_t snsu_decode(input logic [3:0] op, input logic [1:0] sz);
        snsu_ctl_t c;
        c.legal = (op[3:2] == 2'b00) && (sz != SZ_NONE);
        c.rnd   = op[1];
        c.top   = op[0];
        return c;
    endfunction

endpackage

// File: rtl/snsu_lane.sv
module snsu_lane
    import snsu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]       wide,
    input  logic [W/2-1:0]     keep_low,
    input  logic [SHIFT_W-1:0] shamt,
    input  logic               rnd,
    input  logic               top,
    output logic [W-1:0]       packed_out
);
    localparam int H = W / 2;
    localparam logic [SHIFT_W-1:0] W7 = SHIFT_W'(W);

    logic signed [W:0]    ext;
    logic [SHIFT_W-1:0]   eff;
    logic signed [W:0]    shifted;
    logic [W-1:0]         pick;
    logic                 rbit;
    logic                 too_far;
    logic signed [W:0]    summed;
    logic signed [W:0]    val;
    logic [H-1:0]         narrow;

    always_comb begin
        ext     = $signed({wide[W-1], wide});
        too_far = (shamt >= W7);
        eff     = too_far ? (W7 - SHIFT_W'(1)) : shamt;
        shifted = ext >>> eff;
        pick    = {{(W-1){1'b0}}, 1'b1} << (shamt - SHIFT_W'(1));
        rbit    = (shamt != '0) && !too_far && (|(wide & pick));
        summed  = shifted + $signed({{W{1'b0}}, rbit});
        if (rnd) begin
            val = too_far ? '0 : summed;
        end else begin
            val = shifted;
        end
        if (val[W]) begin
            narrow = '0;
        end else if (|val[W-1:H]) begin
            narrow = '1;
        end else begin
            narrow = val[H-1:0];
        end
        packed_out = top ? {narrow, keep_low} : {{H{1'b0}}, narrow};
    end

endmodule

// File: rtl/snsu_vec.sv
module snsu_vec
    import snsu_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic [VEC_W-1:0]   src_vec,
    input  logic [VEC_W-1:0]   dst_vec,
    input  logic [1:0]         elem_size,
    input  logic [SHIFT_W-1:0] shamt,
    input  logic               rnd,
    input  logic               top,
    output logic [VEC_W-1:0]   res_vec
);
    localparam int NSIZES = 3;

    logic [NSIZES-1:0][VEC_W-1:0] per_size;

    for (genvar g = 0; g < NSIZES; g++) begin : g_size
        localparam int CW = 16 << g;
        localparam int NL = VEC_W / CW;
        for (genvar c = 0; c < NL; c++) begin : g_lane
            snsu_lane #(.W(CW)) u_lane (
                .wide       (src_vec[c*CW +: CW]),
                .keep_low   (dst_vec[c*CW +: CW/2]),
                .shamt      (shamt),
                .rnd        (rnd),
                .top        (top),
                .packed_out (per_size[g][c*CW +: CW])
            );
        end
    end

    always_comb begin
        unique case (elem_size)
            SZ_16:   res_vec = per_size[0];
            SZ_32:   res_vec = per_size[1];
            SZ_64:   res_vec = per_size[2];
            default: res_vec = '0;
        endcase
    end

endmodule

// File: rtl/snsu_top.sv
module snsu_top
    import snsu_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] src_vec,
    input  logic [VEC_W-1:0] dst_vec,
    input  logic [1:0]       elem_size,
    input  logic [6:0]       shift_amt,
    input  logic [3:0]       op_code,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_vec
);
    initial begin
        assert (VEC_W % 64 == 0 && VEC_W >= 64)
            else $error("VEC_W must be a multiple of 64");
    end

    snsu_ctl_t   ctl;
    logic        accept;
    logic [VEC_W-1:0] next_vec;
    snsu_state_e state_q, state_d;

    assign ctl    = snsu_decode(op_code, elem_size);
    assign accept = in_valid && ctl.legal;

    snsu_vec #(.VEC_W(VEC_W)) u_vec (
        .src_vec   (src_vec),
        .dst_vec   (dst_vec),
        .elem_size (elem_size),
        .shamt     (shift_amt),
        .rnd       (ctl.rnd),
        .top       (ctl.top),
        .res_vec   (next_vec)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = accept ? ST_EMIT : ST_IDLE;  // accept / hold
            ST_EMIT: state_d = accept ? ST_EMIT : ST_IDLE;  // accept / drain
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n)      out_vec <= '0;
        else if (accept) out_vec <= next_vec;
    end

    assign out_valid = (state_q == ST_EMIT);

    function automatic logic [VEC_W-1:0] low_mask(input logic [1:0] sz);
        logic [VEC_W-1:0] m;
        int cw;
        cw = 8 << sz;
        m = '0;
        for (int i = 0; i < VEC_W; i++) m[i] = ((i % cw) < cw / 2);
        return m;
    endfunction

    assert_strobe_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> out_valid);

    assert_drop_illegal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> (!out_valid && $stable(out_vec)));

    assert_top_keeps_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_code[0]) |=>
        ((out_vec & low_mask($past(elem_size))) == ($past(dst_vec) & low_mask($past(elem_size)))));

    assert_bottom_clears_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !op_code[0]) |=> ((out_vec & ~low_mask($past(elem_size))) == '0));

    assert_reset_quiet_R10: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_vec == '0));

endmodule

// File: tb/snsu_top_tb.sv
module snsu_top_tb;
    localparam int VW = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [VW-1:0] src_vec = '0;
    logic [VW-1:0] dst_vec = '0;
    logic [1:0]    elem_size = 2'd1;
    logic [6:0]    shift_amt = '0;
    logic [3:0]    op_code = '0;
    logic          out_valid;
    logic [VW-1:0] out_vec;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    snsu_top #(.VEC_W(VW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
        .dst_vec(dst_vec), .elem_size(elem_size), .shift_amt(shift_amt),
        .op_code(op_code), .out_valid(out_valid), .out_vec(out_vec)
    );

    task automatic chk(input bit ok, input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // model built from the requirement text
    function automatic longint ref_lane(input longint x, input int w, input int sh, input bit rnd);
        longint v;
        longint mx;
        mx = (longint'(1) <<< (w / 2)) - 1;
        if (!rnd) begin
            v = x >>> ((sh >= w) ? (w - 1) : sh);
        end else if (sh >= w) begin
            v = 0;
        end else if (sh == 0) begin
            v = x;
        end else begin
            v = (x >>> sh) + ((x >>> (sh - 1)) & 1);
        end
        if (v < 0) return 0;
        if (v > mx) return mx;
        return v;
    endfunction

    function automatic logic [VW-1:0] ref_vec(input logic [VW-1:0] s, input logic [VW-1:0] d,
                                              input logic [1:0] sz, input int sh, input logic [3:0] op);
        logic [VW-1:0] r;
        int w;
        int h;
        r = '0;
        w = 8 << sz;
        h = w / 2;
        for (int c = 0; c < VW / w; c++) begin
            logic [63:0] raw;
            logic [63:0] lowd;
            logic [63:0] n;
            logic [63:0] cont;
            longint x;
            raw  = 64'(s >> (c * w));
            lowd = 64'(d >> (c * w)) & ((64'd1 << h) - 1);
            x    = $signed(raw << (64 - w)) >>> (64 - w);
            n    = 64'(ref_lane(x, w, sh, op[1]));
            cont = op[0] ? ((n << h) | lowd) : n;
            if (w < 64) cont = cont & ((64'd1 << w) - 1);
            r = r | (VW'(cont) << (c * w));
        end
        return r;
    endfunction

    task automatic issue(input logic [VW-1:0] s, input logic [VW-1:0] d, input logic [1:0] sz,
                         input int sh, input logic [3:0] op);
        @(negedge clk);
        src_vec = s; dst_vec = d; elem_size = sz; shift_amt = 7'(sh); op_code = op;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_case(input string req, input logic [VW-1:0] s, input logic [VW-1:0] d,
                            input logic [1:0] sz, input int sh, input logic [3:0] op);
        logic [VW-1:0] e;
        e = ref_vec(s, d, sz, sh, op);
        issue(s, d, sz, sh, op);
        chk(out_valid == 1'b1, {req, " R8 strobe"}, VW'(out_valid), VW'(1));
        chk(out_vec == e, req, out_vec, e);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R10 valid", VW'(out_valid), '0);
        chk(out_vec == '0, "R10 vec", out_vec, '0);
        rst_n = 1'b1;
    endtask

    task automatic t_sizes_plain();
        run_case("R1 R2 size16", 128'h8000_7FFF_1234_FF00_00FF_0100_F00F_0F0F, '1, 2'd1, 3, 4'b0000);
        run_case("R1 R2 size32", 128'h8000_0000_7FFF_FFFF_0001_2345_FFFF_FFF0, '1, 2'd2, 4, 4'b0000);
        run_case("R1 R2 size64", 128'h0000_0012_3456_789A_FFFF_FFFF_0000_0000, '1, 2'd3, 8, 4'b0000);
    endtask

    task automatic t_saturate();
        // negatives clamp to 0, large positives to all ones, in-range kept
        run_case("R3 clamp16", 128'hFFFF_8000_7FFF_00FF_0100_0001_FF00_1000, '0, 2'd1, 0, 4'b0000);
        run_case("R3 clamp64", 128'h7FFF_FFFF_FFFF_FFFF_8000_0000_0000_0000, '0, 2'd3, 1, 4'b0000);
    endtask

    task automatic t_round();
        run_case("R4 round16", 128'h0003_0005_0006_0007_FFFF_FFFD_01FF_7FFF, '0, 2'd1, 1, 4'b0010);
        run_case("R4 max64", 128'h7FFF_FFFF_FFFF_FFFF_0000_0001_FFFF_FFFF, '0, 2'd3, 1, 4'b0010);
        run_case("R4 shift0", 128'h0000_00FF_0000_00FE_FFFF_FFFF_0001_0000, '0, 2'd2, 0, 4'b0010);
        run_case("R4 round32", 128'h0000_0180_0000_017F_FFFF_FF80_0001_FF80, '0, 2'd2, 8, 4'b0011);
    endtask

    task automatic t_place();
        run_case("R5 bottom", 128'h1111_2222_3333_4444_5555_6666_7777_0888, '1, 2'd1, 4, 4'b0000);
        run_case("R6 top16", 128'h0123_4567_089A_0BCD_0EF0_0123_0456_0789, 128'hA1B2_C3D4_E5F6_0718_293A_4B5C_6D7E_8F90, 2'd1, 4, 4'b0001);
        run_case("R6 top64", 128'h0000_0000_ABCD_0000_FFFF_FFFF_FFFF_FFFF, 128'h5555_5555_1234_5678_AAAA_AAAA_8765_4321, 2'd3, 16, 4'b0001);
    endtask

    task automatic t_big_shift();
        for (int sz = 1; sz <= 3; sz++) begin
            run_case("R2 wide shift plain", 128'h7FFF_8000_7FFF_FFFF_8000_0000_7FFF_FFFF, '0, 2'(sz), 64, 4'b0000);
            run_case("R4 wide shift round", 128'h7FFF_8000_7FFF_FFFF_8000_0000_7FFF_FFFF, '0, 2'(sz), 100, 4'b0010);
        end
        run_case("R2 shift63", 128'h8000_0000_0000_0000_7FFF_FFFF_FFFF_FFFF, '0, 2'd3, 63, 4'b0000);
        run_case("R4 shift63", 128'hC000_0000_0000_0000_4000_0000_0000_0000, '0, 2'd3, 63, 4'b0010);
    endtask

    task automatic t_opcodes();
        for (int op = 0; op < 4; op++) begin
            run_case("R7 opcode", 128'h0FF7_0FF8_F00F_0109_7000_0017_0180_00FF, 128'h3C3C_3C3C_3C3C_3C3C_3C3C_3C3C_3C3C_3C3C, 2'd1, 4, 4'(op));
        end
    endtask

    task automatic t_pulse();
        logic [VW-1:0] held;
        run_case("R8 first", 128'h0000_1000_0000_2000_0000_3000_0000_4000, '0, 2'd2, 4, 4'b0000);
        held = out_vec;
        @(negedge clk);
        chk(out_valid == 1'b0, "R8 one-cycle strobe", VW'(out_valid), '0);
        chk(out_vec == held, "R8 hold after strobe", out_vec, held);
    endtask

    task automatic t_illegal();
        logic [VW-1:0] held;
        held = out_vec;
        issue('1, '1, 2'd0, 2, 4'b0000);
        chk(out_valid == 1'b0, "R9 size0 strobe", VW'(out_valid), '0);
        chk(out_vec == held, "R9 size0 vec", out_vec, held);
        issue('1, '1, 2'd1, 2, 4'b0100);
        chk(out_valid == 1'b0, "R9 op4 strobe", VW'(out_valid), '0);
        chk(out_vec == held, "R9 op4 vec", out_vec, held);
        issue('1, '1, 2'd2, 2, 4'b1011);
        chk(out_vec == held, "R9 op11 vec", out_vec, held);
    endtask

    task automatic t_mixed();
        for (int i = 0; i < 60; i++) begin
            logic [VW-1:0] s;
            logic [VW-1:0] d;
            s = {$urandom, $urandom, $urandom, $urandom};
            d = {$urandom, $urandom, $urandom, $urandom};
            run_case("R1 mixed", s, d, 2'($urandom_range(1, 3)), int'($urandom_range(0, 70)), 4'($urandom_range(0, 3)));
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        t_reset();
        t_sizes_plain();
        t_saturate();
        t_round();
        t_place();
        t_big_shift();
        t_opcodes();
        t_pulse();
        t_illegal();
        t_mixed();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule